// File: doc/BRIEF.md
# Read Capture Delay Trainer

This block trains the read-side capture delay of each byte lane in a DDR3 memory controller. A `start` pulse begins a session. The block sends a mode-register write that turns on the multipurpose-register read mode. In that mode an ordinary read returns a fixed alternating burst instead of data from the array. The block then steps one shared sweep tap from zero up to the maximum. At each tap it issues one read and checks the captured burst of every lane against the expected pattern.

Each lane keeps the bounds of its first contiguous run of passing taps. After the last tap the block sends a second mode-register write that turns the multipurpose-register mode off. It then drives each lane's stored delay to the centre of that lane's run. A lane that never passed raises its error bit and gets a default delay instead. A programmable idle gap comes after each mode write and after each tap change, before the next read. The delays stay on the outputs for normal reads until the next session starts.

Top module: `rd_level_trainer`

## Requirements
- R1: A `start` pulse while idle or done makes the first command a mode write with `cmd_mpr`=1. No read is issued unless that multipurpose-register mode is on.
- R2: During a session exactly one read is issued per tap, with taps in ascending order from 0 to 2^TAP_W-1. During each read every lane's `tap_out` shows the tap being tried.
- R3: Lane l owns `cap_data[l*64 +: 64]`. Beat b occupies bits [8b+7:8b] of that slice. The lane passes at a tap only if every bit of every even beat is 0 and every bit of every odd beat is 1. A single mismatched bit anywhere in the burst fails the lane.
- R4: When the session ends, each lane that passed at least once gets the delay floor((first+last)/2). Here first and last are the lowest and highest taps of its first contiguous passing run. Passing taps after that run has ended are ignored.
- R5: A lane that passed at no tap sets its bit in `lane_err` and gets the delay DEF_TAP. The other lanes are trained normally.
- R6: After the cycle of a mode write, `cmd_rd` is asserted exactly gap_cycles+2 cycles later. After a change of the sweep tap, `cmd_rd` is asserted exactly gap_cycles+1 cycles later.
- R7: After the read at the last tap has been captured, a mode write with `cmd_mpr`=0 is issued. `done` then rises and stays high, holding `tap_out` and `lane_err` steady, until the next `start`.
- R8: A `start` pulse during a session is ignored: that session continues and its results are unchanged.
- R9: After reset no command is asserted, `done` and `lane_err` are 0, and every lane's `tap_out` equals DEF_TAP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a training session |
| gap_cycles | input | GAP_W | Idle cycles to wait after a mode write or a tap change |
| cmd_mrw | output | 1 | Mode-register write request |
| cmd_mpr | output | 1 | Value of the multipurpose-register bit for the mode write |
| cmd_rd | output | 1 | Read request |
| cap_valid | input | 1 | Captured burst is valid |
| cap_data | input | LANES*64 | Captured 8-beat burst of each lane |
| tap_out | output | LANES*TAP_W | Capture delay per lane |
| done | output | 1 | Training finished, results valid |
| lane_err | output | LANES | Lane found no passing tap |

## Verification
The bench builds the block with two lanes, a 3-bit tap (eight taps) and DEF_TAP=5. This makes all 256 pass/fail patterns across the sweep reachable for lane 0, while lane 1 takes a scrambled companion pattern. The sweep therefore covers empty, full, edge-touching and multi-run masks, with both odd and even run lengths for the centring rule. The gap rotates through 0 to 3 cycles. The corrupted bit of a failing burst moves through all 64 positions, so every beat and bit of the comparison gets exercised.

// File: rtl/rd_level_trainer.sv
module rd_level_trainer #(
  parameter int LANES     = 2,
  parameter int TAP_W     = 4,
  parameter int GAP_W     = 8,
  parameter int DEF_TAP   = 8,
  parameter int BURST     = 8,
  parameter int LANE_BITS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [GAP_W-1:0]         gap_cycles,
  output logic                     cmd_mrw,
  output logic                     cmd_mpr,
  output logic                     cmd_rd,
  input  logic                     cap_valid,
  input  logic [LANES*BURST*LANE_BITS-1:0] cap_data,
  output logic [LANES*TAP_W-1:0]   tap_out,
  output logic                     done,
  output logic [LANES-1:0]         lane_err
);
  localparam int SLICE = BURST * LANE_BITS;
  localparam logic [TAP_W-1:0] TAP_MAX = '1;
  localparam logic [TAP_W-1:0] TAP_DEF = TAP_W'(DEF_TAP);

  typedef enum logic [2:0] {S_IDLE, S_MRW_ON, S_GAP, S_READ, S_WAIT, S_MRW_OFF, S_DONE} st_t;

  st_t              st;
  logic [TAP_W-1:0] tap;
  logic [GAP_W-1:0] cnt;
  logic [SLICE-1:0] golden;

  wire at_rest  = (st == S_IDLE) || (st == S_DONE);
  wire launch   = at_rest && start;
  wire eval     = (st == S_WAIT) && cap_valid;

  assign cmd_mrw = (st == S_MRW_ON) || (st == S_MRW_OFF);
  assign cmd_mpr = (st == S_MRW_ON);
  assign cmd_rd  = (st == S_READ);
  assign done    = (st == S_DONE);

  for (genvar b = 0; b < BURST; b++) begin : g_gold
    assign golden[b*LANE_BITS +: LANE_BITS] = (b % 2 == 1) ? '1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      tap <= '0;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE: if (start) begin
          st  <= S_MRW_ON;
          tap <= '0;
        end
        S_MRW_ON: begin
          cnt <= gap_cycles;
          st  <= S_GAP;
        end
        S_GAP: if (cnt == '0) st <= S_READ;
               else cnt <= cnt - 1'b1;
        S_READ: st <= S_WAIT;
        S_WAIT: if (cap_valid) begin
          if (tap == TAP_MAX) st <= S_MRW_OFF;
          else begin
            tap <= tap + 1'b1;
            cnt <= gap_cycles;
            st  <= S_GAP;
          end
        end
        S_MRW_OFF: st <= S_DONE;
        default:   st <= S_IDLE;
      endcase
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [TAP_W-1:0] first_q, last_q, fin_q;
    logic             found_q, closed_q, err_q;
    wire              pass = (cap_data[l*SLICE +: SLICE] == golden);
    wire  [TAP_W:0]   sum  = {1'b0, first_q} + {1'b0, last_q};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        first_q  <= '0;
        last_q   <= '0;
        found_q  <= 1'b0;
        closed_q <= 1'b0;
        fin_q    <= TAP_DEF;
        err_q    <= 1'b0;
      end else if (launch) begin
        found_q  <= 1'b0;
        closed_q <= 1'b0;
      end else if (eval) begin
        if (pass) begin
          if (!found_q) begin
            first_q <= tap;
            last_q  <= tap;
            found_q <= 1'b1;
          end else if (!closed_q) begin
            last_q <= tap;
          end
        end else if (found_q) begin
          closed_q <= 1'b1;
        end
      end else if (st == S_MRW_OFF) begin
        err_q <= !found_q;
        fin_q <= found_q ? sum[TAP_W:1] : TAP_DEF;
      end
    end

    assign tap_out[l*TAP_W +: TAP_W] = at_rest ? fin_q : tap;
    assign lane_err[l] = err_q;
  end
endmodule

// File: rtl/rd_level_trainer_chk.sv
module rd_level_trainer_chk #(
  parameter int LANES   = 2,
  parameter int TAP_W   = 4,
  parameter int GAP_W   = 8,
  parameter int DEF_TAP = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [GAP_W-1:0]       gap_cycles,
  input logic                   cmd_mrw,
  input logic                   cmd_mpr,
  input logic                   cmd_rd,
  input logic [LANES*TAP_W-1:0] tap_out,
  input logic                   done,
  input logic [LANES-1:0]       lane_err
);
  logic                   mpr_q;
  logic [LANES*TAP_W-1:0] prev_tap_q;
  logic [GAP_W+1:0]       since_q;
  wire                    ev = cmd_mrw || (tap_out != prev_tap_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mpr_q      <= 1'b0;
      prev_tap_q <= '0;
      since_q    <= '1;
    end else begin
      if (cmd_mrw) mpr_q <= cmd_mpr;
      prev_tap_q <= tap_out;
      if (ev) since_q <= 1;
      else if (since_q != '1) since_q <= since_q + 1'b1;
    end
  end

  AST_RD_IN_MPR: assert property (@(posedge clk) disable iff (!rst_n) cmd_rd |-> mpr_q); // R1
  AST_CMD_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(cmd_rd && cmd_mrw)); // R1
  AST_GAP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rd |-> (!ev && since_q > {2'b00, gap_cycles})); // R6
  AST_DONE_AFTER_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(cmd_mrw && !cmd_mpr)); // R7
  AST_DONE_MPR_OFF: assert property (@(posedge clk) disable iff (!rst_n) done |-> !mpr_q); // R7
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> ($stable(tap_out) && $stable(lane_err))); // R7

  for (genvar l = 0; l < LANES; l++) begin : g_err
    AST_ERR_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (done && lane_err[l]) |-> (tap_out[l*TAP_W +: TAP_W] == TAP_W'(DEF_TAP))); // R5
  end
endmodule

bind rd_level_trainer rd_level_trainer_chk #(
  .LANES(LANES), .TAP_W(TAP_W), .GAP_W(GAP_W), .DEF_TAP(DEF_TAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .gap_cycles(gap_cycles), .cmd_mrw(cmd_mrw),
  .cmd_mpr(cmd_mpr), .cmd_rd(cmd_rd), .tap_out(tap_out), .done(done),
  .lane_err(lane_err)
);

// File: tb/test_rd_level_trainer.sv
module test_rd_level_trainer;
  localparam int LANES = 2, TAP_W = 3, GAP_W = 4, DEF = 5, NT = 8;

  logic clk = 0, rst_n = 0, start = 0, cap_valid = 0;
  logic [GAP_W-1:0] gap = '0;
  logic cmd_mrw, cmd_mpr, cmd_rd, done;
  logic [LANES*64-1:0] cap_data = '0;
  logic [LANES*TAP_W-1:0] tap_out;
  logic [LANES-1:0] lane_err;

  always #2.5 clk = ~clk;

  rd_level_trainer #(.LANES(LANES), .TAP_W(TAP_W), .GAP_W(GAP_W), .DEF_TAP(DEF)) i_rd_level_trainer (
    .clk(clk), .rst_n(rst_n), .start(start), .gap_cycles(gap), .cmd_mrw(cmd_mrw),
    .cmd_mpr(cmd_mpr), .cmd_rd(cmd_rd), .cap_valid(cap_valid), .cap_data(cap_data),
    .tap_out(tap_out), .done(done), .lane_err(lane_err));

  int errors = 0, checks = 0;
  logic [7:0] mask [LANES];
  int run = 0;

  int cyc = 0, n_reads = 0, n_cmds = 0, order_bad = 0, tap_bad = 0, gap_bad = 0;
  int evt_cyc = 0, evt_dist = 0, pend = 0, rtap = 0;
  logic [LANES*TAP_W-1:0] prev_tap = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s run=%0d actual=%0d expected=%0d", req, run, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    cap_valid = 0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        cap_valid = 1;
        for (int l = 0; l < LANES; l++) begin
          for (int b = 0; b < 8; b++) cap_data[l*64 + b*8 +: 8] = (b % 2 == 1) ? 8'hFF : 8'h00;
          if (!mask[l][rtap]) cap_data[l*64 + (run*7 + rtap*3 + l*11) % 64] ^= 1'b1;
        end
      end
    end
    if (rst_n) begin
      if (tap_out != prev_tap && !cmd_mrw) begin evt_cyc = cyc; evt_dist = int'(gap) + 1; end
      if (cmd_mrw) begin
        if (cmd_mpr && n_cmds != 0) order_bad++;
        if (!cmd_mpr && n_reads != NT) order_bad++;
        evt_cyc = cyc; evt_dist = int'(gap) + 2;
        n_cmds++;
      end
      if (cmd_rd) begin
        if (n_cmds == 0) order_bad++;
        if (cyc - evt_cyc != evt_dist) gap_bad++;
        for (int l = 0; l < LANES; l++)
          if (int'(tap_out[l*TAP_W +: TAP_W]) != n_reads) tap_bad++;
        rtap = int'(tap_out[TAP_W-1:0]);
        pend = 2;
        n_reads++;
        n_cmds++;
      end
    end
    prev_tap = tap_out;
  end

  task automatic expect_lane(input logic [7:0] m, output int t, output int e);
    int f = -1, la = -1;
    bit closed = 0;
    for (int i = 0; i < NT; i++) begin
      if (m[i]) begin
        if (f < 0) begin f = i; la = i; end
        else if (!closed) la = i;
      end else if (f >= 0) closed = 1;
    end
    if (f < 0) begin t = DEF; e = 1; end
    else begin t = (f + la) / 2; e = 0; end
  endtask

  initial begin : watchdog
    #(5.0 * 190000);
    errors++; checks++;
    $display("FAIL watchdog run=%0d actual=timeout expected=finish", run);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    mask[0] = 8'h00; mask[1] = 8'h00;
    repeat (3) @(negedge clk);
    for (int l = 0; l < LANES; l++)
      chk(int'(tap_out[l*TAP_W +: TAP_W]) == DEF, "R9 reset tap", int'(tap_out[l*TAP_W +: TAP_W]), DEF);
    chk(!done && lane_err == 0 && !cmd_rd && !cmd_mrw, "R9 reset outputs",
        int'({done, lane_err, cmd_rd, cmd_mrw}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!cmd_rd && !cmd_mrw && !done, "R9 idle without start", int'({cmd_rd, cmd_mrw, done}), 0);

    for (int r = 0; r < 256; r++) begin
      int t_exp, e_exp, w;
      run = r;
      mask[0] = 8'(r);
      mask[1] = 8'(r) ^ 8'hA5;
      gap = GAP_W'(r % 4);
      n_reads = 0; n_cmds = 0; order_bad = 0; tap_bad = 0; gap_bad = 0;
      start = 1;
      @(negedge clk);
      start = 0;
      w = 0;
      while (!done && w < 400) begin
        @(negedge clk);
        w++;
        if (r % 5 == 0 && w == 12) start = 1;
        else start = 0;
      end
      start = 0;
      chk(done, "R7 done after session", int'(done), 1);
      chk(order_bad == 0, "R1 R7 command order", order_bad, 0);
      chk(n_reads == NT, "R2 R8 one read per tap", n_reads, NT);
      chk(tap_bad == 0, "R2 tap shown during read", tap_bad, 0);
      chk(gap_bad == 0, "R6 gap before read", gap_bad, 0);
      for (int l = 0; l < LANES; l++) begin
        expect_lane(mask[l], t_exp, e_exp);
        chk(int'(tap_out[l*TAP_W +: TAP_W]) == t_exp, "R3 R4 R5 lane tap",
            int'(tap_out[l*TAP_W +: TAP_W]), t_exp);
        chk(int'(lane_err[l]) == e_exp, "R5 lane error", int'(lane_err[l]), e_exp);
      end
      repeat (3) @(negedge clk);
      chk(done && !cmd_rd && !cmd_mrw, "R7 done held", int'({done, cmd_rd, cmd_mrw}), 4);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule